// File: doc/BRIEF.md
# ATA Task File Command Responder

This block is the device side of a disk-style task file. A host reaches it through a small register port that reads and writes eight offsets. Offset 0 is the data port. Offset 1 holds the error code when read, and writes to it are dropped. Offsets 2 to 5 hold the sector count and three address bytes. Offset 6 is the device/head register. Offset 7 takes a command opcode when written and returns status when read.

The responder runs IDENTIFY itself. It streams 256 sixteen-bit words out of the data port, built from a fixed serial string, a fixed version string and a capability word. It runs FLUSH CACHE as a busy interval that ends when the `flush_done` input is pulsed. It hands the two DMA opcodes to a companion transfer engine as a one-cycle start pulse with a direction flag. Any other opcode is rejected with an abort code. An interrupt line rises when IDENTIFY data is ready, when a flush finishes and when a command is rejected. A status read clears it.

Top module: `ata_taskfile_resp`

## Requirements
- R1: After synchronous reset, status (offset 7) reads 0x40, the error register (offset 1) reads 0x00, offsets 2 to 6 read 0x00, and `irq` is low.
- R2: A byte written to any of offsets 2 to 6 reads back unchanged from the same offset, in the lower 8 bits of `host_rdata`, with the upper bits zero.
- R3: Status bits are busy 0x80, ready 0x40, fault 0x20, data-request 0x08 and error 0x01, and ready is always set. A status read drops `irq` in the next cycle unless a new interrupt event happens in that same cycle, in which case `irq` stays high.
- R4: Opcode 0xEC starts IDENTIFY. Status becomes 0x48 and `irq` rises. Each read of offset 0 returns the next of 256 words and advances one word. After the 256th read, status returns to 0x40.
- R5: IDENTIFY words 10 to 19 carry the 20-character serial "TF-UNIT-0042" padded with spaces, and words 23 to 26 carry the 8-character version "REV 1.3 ". Each word holds its earlier character in bits 15:8.
- R6: IDENTIFY word 85 is 0x0020, with bit 5 reporting an enabled write cache. Every word not named in R5 or R6 is 0x0000.
- R7: Opcode 0xE7 makes status 0xC0 until `flush_done` is sampled high. One cycle later status is 0x40 and `irq` is high. A `flush_done` pulse outside a flush has no effect.
- R8: Any opcode other than 0xEC, 0xE7, 0xC8 or 0xCA sets status to 0x41 and the error register to 0x04 (abort), and raises `irq`. The next accepted command clears both.
- R9: Opcodes 0xC8 and 0xCA pulse `dma_start` for exactly one cycle, in the cycle after the write. `dma_to_host` is 1 for 0xC8 and 0 for 0xCA. Status stays 0x40 and `irq` is not raised.
- R10: A command written while status shows busy or data-request is ignored: status, error register and `irq` behave as if no write had happened.
- R11: While bit 4 (0x10) of the device register is set, command writes are ignored. Bit 6 (0x40, address mode) is only stored.
- R12: Reading offset 0 while data-request is clear returns 0x0000 and advances nothing. Writes to offset 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe; reads of offsets 0 and 7 have side effects |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Write data; only bits 7:0 are used |
| host_rdata | output | 16 | Read data for `host_addr`, combinational |
| flush_done | input | 1 | Completion pulse for an in-flight flush |
| irq | output | 1 | Interrupt request |
| dma_start | output | 1 | One-cycle start pulse to the DMA engine |
| dma_to_host | output | 1 | DMA direction: 1 = device to host |

## Verification
The hardest situation to reach is the race on the interrupt line: a status read and an interrupt source arriving in the same cycle. The stimulus starts a flush and then drives `flush_done` in the same cycle as a status read, so the clear and the set collide. A second corner is a command written during an IDENTIFY transfer partway through the 256 words, when the transfer must go on undisturbed. The bench reaches it by issuing the write between two data reads in the middle of the stream. A behavioural reference model checks the interrupt, the DMA pulse and every read value on every clock.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int TF_AW = 3;
    localparam int TF_DW = 16;

    localparam logic [TF_AW-1:0] OFF_DATA = 3'd0;
    localparam logic [TF_AW-1:0] OFF_ERR  = 3'd1;
    localparam logic [TF_AW-1:0] OFF_CMD  = 3'd7;

    localparam int REG_LO  = 2;
    localparam int REG_HI  = 6;
    localparam int REG_DEV = 6;

    localparam int DEV_SEL_BIT = 4;
    localparam int ABRT_BIT    = 2;

    localparam logic [7:0] OP_IDENTIFY = 8'hEC;
    localparam logic [7:0] OP_FLUSH    = 8'hE7;
    localparam logic [7:0] OP_RD_DMA   = 8'hC8;
    localparam logic [7:0] OP_WR_DMA   = 8'hCA;

    typedef enum logic [1:0] {TF_IDLE, TF_IDENT, TF_FLUSH} tf_state_e;
    typedef enum logic [1:0] {K_IDENT, K_FLUSH, K_DMA, K_BAD} tf_kind_e;

    typedef struct packed {
        logic bsy;
        logic drdy;
        logic df;
        logic rsv4;
        logic drq;
        logic rsv2;
        logic rsv1;
        logic err;
    } tf_status_t;

    function automatic tf_status_t build_status(logic bsy, logic drq, logic err);
        tf_status_t s;
        s      = '0;
        s.bsy  = bsy;
        s.drdy = 1'b1;
        s.drq  = drq;
        s.err  = err;
        return s;
    endfunction

    function automatic tf_kind_e classify(logic [7:0] op);
        case (op)
            OP_IDENTIFY:          return K_IDENT;
            OP_FLUSH:             return K_FLUSH;
            OP_RD_DMA, OP_WR_DMA: return K_DMA;
            default:              return K_BAD;
        endcase
    endfunction

endpackage

// File: rtl/ata_ident_rom.sv
module ata_ident_rom
    import ata_tf_pkg::*;
#(
    parameter int IDENT_WORDS = 256,
    parameter int SER_CHARS   = 20,
    parameter int VER_CHARS   = 8,
    parameter logic [8*SER_CHARS-1:0] SERIAL  = "TF-UNIT-0042        ",
    parameter logic [8*VER_CHARS-1:0] VERSION = "REV 1.3 ",
    parameter int SER_BASE  = 10,
    parameter int VER_BASE  = 23,
    parameter int CAP_IDX   = 85,
    parameter logic [TF_DW-1:0] CAP_VALUE = 16'h0020,
    localparam int WAW = $clog2(IDENT_WORDS)
) (
    input  logic [WAW-1:0]   idx,
    output logic [TF_DW-1:0] word
);
    localparam int SER_WORDS = SER_CHARS / 2;
    localparam int VER_WORDS = VER_CHARS / 2;

    logic [TF_DW-1:0] ser_w [SER_WORDS];
    logic [TF_DW-1:0] ver_w [VER_WORDS];

    // earlier character lands in the high byte of each word
    for (genvar j = 0; j < SER_WORDS; j++) begin : gen_ser
        assign ser_w[j] = SERIAL[16*(SER_WORDS-1-j) +: 16];
    end
    for (genvar j = 0; j < VER_WORDS; j++) begin : gen_ver
        assign ver_w[j] = VERSION[16*(VER_WORDS-1-j) +: 16];
    end

    logic [31:0] idx32;
    assign idx32 = 32'(idx);

    always_comb begin
        word = '0;
        for (int j = 0; j < SER_WORDS; j++)
            if (idx32 == 32'(SER_BASE + j)) word = ser_w[j];
        for (int j = 0; j < VER_WORDS; j++)
            if (idx32 == 32'(VER_BASE + j)) word = ver_w[j];
        if (idx32 == 32'(CAP_IDX)) word = CAP_VALUE;
    end

endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
    import ata_tf_pkg::*;
#(
    parameter int IDENT_WORDS = 256,
    localparam int WAW = $clog2(IDENT_WORDS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_wr,
    input  logic [7:0]     cmd_code,
    input  logic           data_rd,
    input  logic           stat_rd,
    input  logic           flush_done,
    output logic           bsy,
    output logic           drq,
    output logic           err,
    output logic           abrt,
    output logic           irq,
    output logic [WAW-1:0] word_idx,
    output logic           dma_start,
    output logic           dma_to_host
);
    localparam logic [WAW-1:0] LAST_IDX = WAW'(IDENT_WORDS - 1);

    tf_state_e state;
    tf_kind_e  kind;
    logic      accept;
    logic      irq_set;

    assign bsy    = (state == TF_FLUSH);
    assign drq    = (state == TF_IDENT);
    assign kind   = classify(cmd_code);
    assign accept = cmd_wr && (state == TF_IDLE);

    always_comb begin
        irq_set = 1'b0;
        if (accept && (kind == K_IDENT || kind == K_BAD)) irq_set = 1'b1;
        if (state == TF_FLUSH && flush_done)              irq_set = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= TF_IDLE;
            err         <= 1'b0;
            abrt        <= 1'b0;
            irq         <= 1'b0;
            word_idx    <= '0;
            dma_start   <= 1'b0;
            dma_to_host <= 1'b0;
        end else begin
            dma_start <= 1'b0;
            irq       <= irq_set | (irq & ~stat_rd);
            case (state)
                TF_IDLE: if (accept) begin
                    err  <= 1'b0;
                    abrt <= 1'b0;
                    case (kind)
                        K_IDENT: begin
                            state    <= TF_IDENT;
                            word_idx <= '0;
                        end
                        K_FLUSH: state <= TF_FLUSH;
                        K_DMA: begin
                            dma_start   <= 1'b1;
                            dma_to_host <= (cmd_code == OP_RD_DMA);
                        end
                        default: begin
                            err  <= 1'b1;
                            abrt <= 1'b1;
                        end
                    endcase
                end
                TF_IDENT: if (data_rd) begin
                    word_idx <= word_idx + WAW'(1);
                    if (word_idx == LAST_IDX) state <= TF_IDLE;
                end
                TF_FLUSH: if (flush_done) state <= TF_IDLE;
                default: state <= TF_IDLE;
            endcase
        end
    end

    a_r3_status_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !irq_set) |=> !irq);

    a_r7_flush_holds_busy: assert property (@(posedge clk) disable iff (rst)
        (bsy && !flush_done) |=> bsy);

    a_r7_flush_done_irq: assert property (@(posedge clk) disable iff (rst)
        (bsy && flush_done) |=> (!bsy && irq));

    a_r9_dma_single_pulse: assert property (@(posedge clk) disable iff (rst)
        dma_start |=> !dma_start);

    a_r10_busy_ignores_cmd: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && (bsy || drq)) |=> ($stable(err) && $stable(abrt) && !dma_start));

    a_r4_word_advance: assert property (@(posedge clk) disable iff (rst)
        (drq && data_rd && word_idx != LAST_IDX) |=> (drq && word_idx == $past(word_idx) + WAW'(1)));

endmodule

// File: rtl/ata_taskfile_resp.sv
module ata_taskfile_resp
    import ata_tf_pkg::*;
#(
    parameter int IDENT_WORDS = 256,
    parameter int SER_CHARS   = 20,
    parameter int VER_CHARS   = 8,
    parameter logic [8*SER_CHARS-1:0] SERIAL  = "TF-UNIT-0042        ",
    parameter logic [8*VER_CHARS-1:0] VERSION = "REV 1.3 ",
    parameter int CAP_IDX = 85,
    parameter logic [TF_DW-1:0] CAP_VALUE = 16'h0020
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [TF_AW-1:0] host_addr,
    input  logic [TF_DW-1:0] host_wdata,
    output logic [TF_DW-1:0] host_rdata,
    input  logic             flush_done,
    output logic             irq,
    output logic             dma_start,
    output logic             dma_to_host
);
    localparam int WAW = $clog2(IDENT_WORDS);

    logic [7:0] reg_view [REG_LO:REG_HI];

    for (genvar g = REG_LO; g <= REG_HI; g++) begin : gen_reg
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (host_wr && host_addr == TF_AW'(g))
                q <= host_wdata[7:0];
        end
        assign reg_view[g] = q;
    end

    logic unused_wdata;
    assign unused_wdata = ^host_wdata[TF_DW-1:8];

    logic dev_sel1, cmd_wr, data_rd, stat_rd;
    assign dev_sel1 = reg_view[REG_DEV][DEV_SEL_BIT];
    assign cmd_wr   = host_wr && host_addr == OFF_CMD && !dev_sel1;
    assign data_rd  = host_rd && host_addr == OFF_DATA;
    assign stat_rd  = host_rd && host_addr == OFF_CMD;

    logic bsy, drq, err, abrt;
    logic [WAW-1:0]   word_idx;
    logic [TF_DW-1:0] ident_word;
    tf_status_t       status;

    ata_tf_ctrl #(.IDENT_WORDS(IDENT_WORDS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (cmd_wr),
        .cmd_code    (host_wdata[7:0]),
        .data_rd     (data_rd),
        .stat_rd     (stat_rd),
        .flush_done  (flush_done),
        .bsy         (bsy),
        .drq         (drq),
        .err         (err),
        .abrt        (abrt),
        .irq         (irq),
        .word_idx    (word_idx),
        .dma_start   (dma_start),
        .dma_to_host (dma_to_host)
    );

    ata_ident_rom #(
        .IDENT_WORDS (IDENT_WORDS),
        .SER_CHARS   (SER_CHARS),
        .VER_CHARS   (VER_CHARS),
        .SERIAL      (SERIAL),
        .VERSION     (VERSION),
        .CAP_IDX     (CAP_IDX),
        .CAP_VALUE   (CAP_VALUE)
    ) u_rom (
        .idx  (word_idx),
        .word (ident_word)
    );

    assign status = build_status(bsy, drq, err);

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFF_DATA: if (drq) host_rdata = ident_word;
            OFF_ERR:  host_rdata[ABRT_BIT] = abrt;
            OFF_CMD:  host_rdata[7:0] = status;
            default:  host_rdata[7:0] = reg_view[host_addr];
        endcase
    end

    // R11: a command to the other device changes nothing
    a_r11_dev1_no_cmd: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == OFF_CMD && dev_sel1 && !host_rd && !bsy)
        |=> ($stable(status) && $stable(irq) && !dma_start));

endmodule

// File: tb/test_ata_taskfile_resp.sv
module test_ata_taskfile_resp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0, host_rd = 1'b0, flush_done = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        irq, dma_start, dma_to_host;

    always #5 clk = ~clk;

    ata_taskfile_resp i_ata_taskfile_resp (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .flush_done(flush_done), .irq(irq), .dma_start(dma_start),
        .dma_to_host(dma_to_host)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // reference model state
    int         m_state;   // 0 idle, 1 identify, 2 flush
    int         m_ptr;
    bit         m_err, m_abrt, m_irq, m_dma, m_dir;
    bit [7:0]   m_tf [2:6];
    logic [15:0] ident [256];
    logic [15:0] last_rd;
    bit          last_irq, last_dma, last_dir;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_read(input bit [2:0] a);
        case (a)
            3'd0: return (m_state == 1) ? ident[m_ptr] : 16'h0000;
            3'd1: return m_abrt ? 16'h0004 : 16'h0000;
            3'd7: return 16'h0040 | ((m_state == 2) ? 16'h0080 : 16'h0)
                        | ((m_state == 1) ? 16'h0008 : 16'h0) | (m_err ? 16'h0001 : 16'h0);
            default: return {8'h00, m_tf[a]};
        endcase
    endfunction

    task automatic model_update(input bit wr, input bit rd, input bit [2:0] a,
                                input bit [15:0] d, input bit fd);
        bit acc, setirq, dma_n;
        acc    = wr && a == 3'd7 && !m_tf[6][4] && m_state == 0;
        setirq = 0;
        dma_n  = 0;
        if (m_state == 1 && rd && a == 3'd0) begin
            if (m_ptr == 255) m_state = 0;
            m_ptr++;
        end else if (m_state == 2 && fd) begin
            m_state = 0;
            setirq  = 1;
        end
        if (acc) begin
            m_err = 0; m_abrt = 0;
            case (d[7:0])
                8'hEC: begin m_state = 1; m_ptr = 0; setirq = 1; end
                8'hE7: m_state = 2;
                8'hC8, 8'hCA: begin dma_n = 1; m_dir = (d[7:0] == 8'hC8); end
                default: begin m_err = 1; m_abrt = 1; setirq = 1; end
            endcase
        end
        if (rd && a == 3'd7) m_irq = 0;
        if (setirq) m_irq = 1;
        m_dma = dma_n;
        if (wr && a >= 3'd2 && a <= 3'd6) m_tf[a] = d[7:0];
    endtask

    // one clock of stimulus, compared against the model
    task automatic op(input string tag, input bit wr, input bit rd, input bit [2:0] a,
                      input bit [15:0] d, input bit fd);
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d; flush_done = fd;
        #1;
        last_rd = host_rdata; last_irq = irq; last_dma = dma_start; last_dir = dma_to_host;
        if (rd) chk(tag, host_rdata, exp_read(a));
        chk(tag, {15'b0, irq}, {15'b0, m_irq});
        chk(tag, {15'b0, dma_start}, {15'b0, m_dma});
        if (m_dma) chk(tag, {15'b0, dma_to_host}, {15'b0, m_dir});
        @(posedge clk);
        model_update(wr, rd, a, d, fd);
    endtask

    task automatic rd_expect(input string tag, input bit [2:0] a, input logic [15:0] exp);
        op(tag, 0, 1, a, 16'h0, 0);
        chk(tag, last_rd, exp);
    endtask

    task automatic idle(input string tag);
        op(tag, 0, 0, 3'd0, 16'h0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        string ser, ver;
        ser = "TF-UNIT-0042        ";
        ver = "REV 1.3 ";
        for (int i = 0; i < 256; i++) ident[i] = 16'h0000;
        for (int i = 0; i < 10; i++) ident[10 + i] = {ser[2*i], ser[2*i+1]};
        for (int i = 0; i < 4; i++)  ident[23 + i] = {ver[2*i], ver[2*i+1]};
        ident[85] = 16'h0020;
        m_state = 0; m_ptr = 0; m_err = 0; m_abrt = 0; m_irq = 0; m_dma = 0; m_dir = 0;
        for (int i = 2; i <= 6; i++) m_tf[i] = 8'h00;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd_expect("R1", 3'd7, 16'h0040);
        rd_expect("R1", 3'd1, 16'h0000);
        for (int i = 2; i <= 6; i++) rd_expect("R1", 3'(i), 16'h0000);
        chk("R1", {15'b0, last_irq}, 16'h0);

        // R2 register file
        op("R2", 1, 0, 3'd2, 16'hFFA5, 0);
        op("R2", 1, 0, 3'd3, 16'h003C, 0);
        op("R2", 1, 0, 3'd4, 16'h00C3, 0);
        op("R2", 1, 0, 3'd5, 16'h005A, 0);
        op("R2", 1, 0, 3'd6, 16'h0040, 0);
        rd_expect("R2", 3'd2, 16'h00A5);
        rd_expect("R2", 3'd3, 16'h003C);
        rd_expect("R2", 3'd4, 16'h00C3);
        rd_expect("R2", 3'd5, 16'h005A);
        rd_expect("R2", 3'd6, 16'h0040);

        // R12 data port when idle
        rd_expect("R12", 3'd0, 16'h0000);
        op("R12", 1, 0, 3'd0, 16'hBEEF, 0);
        rd_expect("R12", 3'd0, 16'h0000);
        rd_expect("R12", 3'd7, 16'h0040);

        // R4 identify stream, with R5/R6 word contents and R10 mid-stream command
        op("R4", 1, 0, 3'd7, 16'h00EC, 0);
        idle("R4");
        chk("R4", {15'b0, last_irq}, 16'h1);
        rd_expect("R4", 3'd7, 16'h0048);
        idle("R3");
        chk("R3", {15'b0, last_irq}, 16'h0);
        for (int i = 0; i < 256; i++) begin
            if (i == 100) begin
                op("R10", 1, 0, 3'd7, 16'h00E7, 0);
                rd_expect("R10", 3'd7, 16'h0048);
            end
            rd_expect("R4", 3'd7, 16'h0048);
            if (i >= 10 && i <= 26)  rd_expect("R5", 3'd0, ident[i]);
            else if (i == 85)        rd_expect("R6", 3'd0, 16'h0020);
            else                     rd_expect("R6", 3'd0, 16'h0000);
        end
        rd_expect("R4", 3'd7, 16'h0040);
        rd_expect("R12", 3'd0, 16'h0000);

        // R7 flush
        op("R7", 1, 0, 3'd7, 16'h00E7, 0);
        for (int i = 0; i < 3; i++) rd_expect("R7", 3'd7, 16'h00C0);
        op("R10", 1, 0, 3'd7, 16'h00EC, 0);
        rd_expect("R10", 3'd7, 16'h00C0);
        op("R7", 0, 0, 3'd0, 16'h0, 1);
        idle("R7");
        chk("R7", {15'b0, last_irq}, 16'h1);
        rd_expect("R7", 3'd7, 16'h0040);
        idle("R7");
        chk("R7", {15'b0, last_irq}, 16'h0);
        op("R7", 0, 0, 3'd0, 16'h0, 1);
        idle("R7");
        chk("R7", {15'b0, last_irq}, 16'h0);
        rd_expect("R7", 3'd7, 16'h0040);

        // R3 status read colliding with flush completion
        op("R3", 1, 0, 3'd7, 16'h00E7, 0);
        op("R3", 0, 1, 3'd7, 16'h0, 1);
        idle("R3");
        chk("R3", {15'b0, last_irq}, 16'h1);
        rd_expect("R3", 3'd7, 16'h0040);
        idle("R3");
        chk("R3", {15'b0, last_irq}, 16'h0);

        // R8 unsupported opcode
        op("R8", 1, 0, 3'd7, 16'h0055, 0);
        rd_expect("R8", 3'd7, 16'h0041);
        rd_expect("R8", 3'd1, 16'h0004);
        idle("R8");
        chk("R8", {15'b0, last_irq}, 16'h0);

        // R9 DMA hand-off, also clearing the abort of R8
        op("R9", 1, 0, 3'd7, 16'h00C8, 0);
        idle("R9");
        chk("R9", {15'b0, last_dma}, 16'h1);
        chk("R9", {15'b0, last_dir}, 16'h1);
        idle("R9");
        chk("R9", {15'b0, last_dma}, 16'h0);
        rd_expect("R8", 3'd7, 16'h0040);
        rd_expect("R8", 3'd1, 16'h0000);
        op("R9", 1, 0, 3'd7, 16'h00CA, 0);
        idle("R9");
        chk("R9", {15'b0, last_dma}, 16'h1);
        chk("R9", {15'b0, last_dir}, 16'h0);
        chk("R9", {15'b0, last_irq}, 16'h0);
        rd_expect("R9", 3'd7, 16'h0040);

        // R11 device 1 selected
        op("R11", 1, 0, 3'd6, 16'h0050, 0);
        op("R11", 1, 0, 3'd7, 16'h00EC, 0);
        rd_expect("R11", 3'd7, 16'h0040);
        chk("R11", {15'b0, last_irq}, 16'h0);
        op("R11", 1, 0, 3'd7, 16'h0033, 0);
        rd_expect("R11", 3'd1, 16'h0000);
        op("R11", 1, 0, 3'd6, 16'h0040, 0);
        rd_expect("R11", 3'd6, 16'h0040);
        idle("R11");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule